// File: doc/BRIEF.md
# Movable Sprite Position and Serializer

This block draws one movable eight-pixel object on a raster line of 160 visible pixel clocks. A free-running position counter advances only on counted clocks. Whenever it passes a start decode, an eight-bit graphics byte is shifted out one bit per pixel on a single serial output. Priority and colour are handled elsewhere; this block only decides, for each visible clock, whether the object covers that pixel.

Software places the object with a position-reset strobe. It moves the object with a signed four-bit motion value, which takes effect only when a global move strobe fires at the start of horizontal blank. That strobe injects extra counter clocks during blank and withholds the first eight visible clocks of the line, so the net shift equals the motion value. A three-bit size field selects either extra copies on the line or a wider pixel. A reflect bit reverses the scan order. A second graphics register, refreshed when the companion object's graphics byte is written, gives a one-line vertical delay that the vertical-delay bit can select.

All control writes share the byte bus `wr_data_i`. Each register has its own write strobe, and the value is captured on the rising clock edge where that strobe is high.

Top module: `movobj_engine`

## Requirements
- R1: The position counter counts modulo 160 and advances only on visible clocks (`hblank_i` low) and on injected move clocks. With no writes, the object starts in the same column on every line.
- R2: A high `pos_rst_i` on a clock edge clears the counter. If this happens during blank, the object starts in visible column 0. If it happens on the edge of visible column v, the object starts in column v+1 on that line and on following lines.
- R3: The size field is `wr_data_i[2:0]`, written with `wr_size_i`. Extra copies start at these offsets from the primary start: 0 none, 1 +16, 2 +32, 3 +16 and +32, 4 +64, 6 +32 and +64.
- R4: Size 5 holds each graphics bit for 2 clocks, for an object 16 wide. Size 7 holds each bit for 4 clocks, for an object 32 wide. Each of these sizes draws a single copy.
- R5: The reflect bit is `wr_data_i[0]`, written with `wr_refl_i`. When it is 0, the byte is output bit 7 first. When it is 1, the byte is output bit 0 first.
- R6: The motion value is `wr_data_i[7:4]`, a two's-complement number m, written with `wr_motion_i`. A high `hmove_i` on the first blank edge of a line has these effects on that line:
  - 8+m counter clocks are injected, one every 4 blank clocks.
  - The first 8 visible clocks are neither counted nor drawn.
  - The object moves m columns left.
  - The shift happens once per strobe. Writing a motion value alone moves nothing.
- R7: A high `mclr_i` zeroes the motion value, so a following move strobe leaves the position unchanged.
- R8: `wr_gfx_i` loads the direct register from `wr_data_i`. `wr_peer_gfx_i` copies the direct register into the delayed register. The vertical-delay bit (`wr_data_i[0]`, written with `wr_vdel_i`) selects the delayed register when it is 1 and the direct register when it is 0.
- R9: A start decode that arrives while a scan is still running is ignored, and the running scan completes unchanged.
- R10: After reset, the graphics, size, reflect, vertical-delay and motion registers are zero, and `pix_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hblank_i | input | 1 | High during horizontal blank |
| wr_data_i | input | 8 | Write data byte shared by all strobes |
| wr_gfx_i | input | 1 | Load the direct graphics register |
| wr_peer_gfx_i | input | 1 | Companion object's graphics write; copies direct to delayed |
| wr_size_i | input | 1 | Load the size field from data[2:0] |
| wr_refl_i | input | 1 | Load the reflect bit from data[0] |
| wr_vdel_i | input | 1 | Load the vertical-delay select from data[0] |
| wr_motion_i | input | 1 | Load the motion value from data[7:4] |
| mclr_i | input | 1 | Clear the motion value |
| hmove_i | input | 1 | Global move strobe, issued on the first blank clock |
| pos_rst_i | input | 1 | Position-counter reset strobe |
| pix_o | output | 1 | Serial object pixel for the current visible column |

## Verification
The hardest situation to reach is the move window. The net shift emerges only from the sum of injected blank clocks and the eight withheld visible clocks, and the window only lines up when the strobe lands exactly on the first blank edge. The stimulus therefore pulses the move strobe in the first blank cycle of a line. It loads the next motion value later in the same blank, so every extreme of m, including zero after a clear, is taken through a full window. A second hard case is a start decode that arrives during an active scan. The bench creates one by pulsing the position reset three columns into a visible object. It then checks that the drawn pattern is unbroken and that the following line starts one column later.

// File: rtl/movobj_pkg.sv
package movobj_pkg;

  localparam int SIZE_W = 3;
  localparam int WLOG_W = 2;

  // copy_mask[0]: near copy, [1]: middle copy, [2]: far copy
  typedef struct packed {
    logic [2:0]        copy_mask;
    logic [WLOG_W-1:0] wlog;
  } size_cfg_t;

  function automatic size_cfg_t size_decode(input logic [SIZE_W-1:0] sz);
    size_cfg_t c;
    c = '0;
    case (sz)
      3'd1:    c.copy_mask = 3'b001;
      3'd2:    c.copy_mask = 3'b010;
      3'd3:    c.copy_mask = 3'b011;
      3'd4:    c.copy_mask = 3'b100;
      3'd5:    c.wlog      = 2'd1;
      3'd6:    c.copy_mask = 3'b110;
      3'd7:    c.wlog      = 2'd2;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/movobj_motion.sv
module movobj_motion #(
  parameter int MOT_W     = 4,
  parameter int LATE_CLKS = 8,
  parameter int EXTRA_GAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hblank_i,
  input  logic             wr_mot_i,
  input  logic [MOT_W-1:0] mot_data_i,
  input  logic             mclr_i,
  input  logic             hmove_i,
  output logic             extra_o,
  output logic             hold_o
);

  localparam int MAX_EXTRA = LATE_CLKS + (1 << (MOT_W - 1)) - 1;
  localparam int PEND_W    = $clog2(MAX_EXTRA + 1);
  localparam int LW        = $clog2(LATE_CLKS + 1);
  localparam int GW        = (EXTRA_GAP > 1) ? $clog2(EXTRA_GAP) : 1;

  logic [MOT_W-1:0]  mval_q, mval_d;
  logic [PEND_W-1:0] pend_q, pend_d, pend_load;
  logic [GW-1:0]     gap_q, gap_d;
  logic              run_q, run_d;
  logic              late_q, late_d;
  logic [LW-1:0]     lcnt_q, lcnt_d;

  assign pend_load = PEND_W'(LATE_CLKS + int'($signed(mval_q)));
  assign extra_o   = run_q && hblank_i && (gap_q == GW'(EXTRA_GAP - 1));
  assign hold_o    = late_q && !hblank_i;

  always_comb begin
    mval_d = mval_q;
    if (mclr_i)        mval_d = '0;
    else if (wr_mot_i) mval_d = mot_data_i;

    pend_d = pend_q;
    gap_d  = gap_q;
    run_d  = run_q;
    late_d = late_q;
    lcnt_d = lcnt_q;
    if (hmove_i) begin
      pend_d = pend_load;
      gap_d  = '0;
      run_d  = (pend_load != '0);
      late_d = 1'b1;
      lcnt_d = '0;
    end else begin
      if (run_q) begin
        if (!hblank_i) begin
          run_d = 1'b0;
        end else begin
          gap_d = (gap_q == GW'(EXTRA_GAP - 1)) ? '0 : gap_q + 1'b1;
          if (extra_o) begin
            pend_d = pend_q - 1'b1;
            if (pend_q == PEND_W'(1)) run_d = 1'b0;
          end
        end
      end
      if (hold_o) begin
        lcnt_d = lcnt_q + 1'b1;
        if (lcnt_q == LW'(LATE_CLKS - 1)) late_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mval_q <= '0;
      pend_q <= '0;
      gap_q  <= '0;
      run_q  <= 1'b0;
      late_q <= 1'b0;
      lcnt_q <= '0;
    end else begin
      mval_q <= mval_d;
      pend_q <= pend_d;
      gap_q  <= gap_d;
      run_q  <= run_d;
      late_q <= late_d;
      lcnt_q <= lcnt_d;
    end
  end

  // R6
  extra_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_o |=> !extra_o);

  // R6
  hold_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(late_q) |-> $past(hmove_i));

  // R7
  mclr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (mval_q == '0));

endmodule

// File: rtl/movobj_poscnt.sv
module movobj_poscnt #(
  parameter int LINE_PIX  = 160,
  parameter int COPY_NEAR = 16,
  parameter int COPY_MID  = 32,
  parameter int COPY_FAR  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       extra_i,
  input  logic       pos_rst_i,
  input  logic [2:0] copy_mask_i,
  output logic       cnt_clk_o,
  output logic       start_o
);

  localparam int CW = $clog2(LINE_PIX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    copy_hit;

  for (genvar i = 0; i < 3; i++) begin : g_copy
    localparam int OFF = (i == 0) ? COPY_NEAR : ((i == 1) ? COPY_MID : COPY_FAR);
    assign copy_hit[i] = copy_mask_i[i] && (cnt_q == CW'(OFF));
  end

  assign cnt_clk_o = tick_i || extra_i;
  assign start_o   = cnt_clk_o && ((cnt_q == '0) || (|copy_hit));

  always_comb begin
    cnt_d = cnt_q;
    if (pos_rst_i)      cnt_d = '0;
    else if (cnt_clk_o) cnt_d = (cnt_q == CW'(LINE_PIX - 1)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LINE_PIX);

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clk_o && !pos_rst_i) |=> $stable(cnt_q));

  // R2
  pos_rst_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_rst_i |=> (cnt_q == '0));

endmodule

// File: rtl/movobj_scan.sv
module movobj_scan #(
  parameter int GFX_W  = 8,
  parameter int WLOG_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clk_i,
  input  logic              start_i,
  input  logic              vis_i,
  input  logic [GFX_W-1:0]  gfx_i,
  input  logic              refl_i,
  input  logic [WLOG_W-1:0] wlog_i,
  output logic              pix_o
);

  localparam int IW     = $clog2(GFX_W);
  localparam int MAX_WL = (1 << WLOG_W) - 1;
  localparam int SUB_W  = (MAX_WL > 0) ? MAX_WL : 1;

  logic             act_q, act_d;
  logic [IW-1:0]    bidx_q, bidx_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             vis_q;
  logic [SUB_W-1:0] sub_last;
  logic [IW-1:0]    sel;

  assign sub_last = SUB_W'((1 << wlog_i) - 1);
  assign sel      = refl_i ? bidx_q : (IW'(GFX_W - 1) - bidx_q);
  assign pix_o    = act_q && vis_q && gfx_i[sel];

  always_comb begin
    act_d  = act_q;
    bidx_d = bidx_q;
    sub_d  = sub_q;
    if (cnt_clk_i) begin
      if (!act_q) begin
        if (start_i) begin
          act_d  = 1'b1;
          bidx_d = '0;
          sub_d  = '0;
        end
      end else if (sub_q == sub_last) begin
        sub_d = '0;
        if (bidx_q == IW'(GFX_W - 1)) act_d = 1'b0;
        else                          bidx_d = bidx_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bidx_q <= '0;
      sub_q  <= '0;
      vis_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      bidx_q <= bidx_d;
      sub_q  <= sub_d;
      vis_q  <= vis_i;
    end
  end

  // R4
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_clk_i && (sub_q != sub_last)) |=> (act_q && $stable(bidx_q)));

  // R9
  no_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && start_i) |=> !(act_q && (bidx_q == '0) && (sub_q == '0)));

endmodule

// File: rtl/movobj_engine.sv
module movobj_engine
  import movobj_pkg::*;
#(
  parameter int LINE_PIX  = 160,
  parameter int GFX_W     = 8,
  parameter int MOT_W     = 4,
  parameter int LATE_CLKS = 8,
  parameter int EXTRA_GAP = 4,
  parameter int COPY_NEAR = 16,
  parameter int COPY_MID  = 32,
  parameter int COPY_FAR  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hblank_i,
  input  logic [GFX_W-1:0] wr_data_i,
  input  logic             wr_gfx_i,
  input  logic             wr_peer_gfx_i,
  input  logic             wr_size_i,
  input  logic             wr_refl_i,
  input  logic             wr_vdel_i,
  input  logic             wr_motion_i,
  input  logic             mclr_i,
  input  logic             hmove_i,
  input  logic             pos_rst_i,
  output logic             pix_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [GFX_W-1:0]  gfx_new_q, gfx_new_d, gfx_old_q, gfx_old_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              refl_q, refl_d, vdel_q, vdel_d;
  size_cfg_t         size_cfg;
  logic              extra, hold, tick, cnt_clk, start;

  always_comb begin
    gfx_new_d = wr_gfx_i      ? wr_data_i               : gfx_new_q;
    gfx_old_d = wr_peer_gfx_i ? gfx_new_q               : gfx_old_q;
    size_d    = wr_size_i     ? wr_data_i[SIZE_W-1:0]   : size_q;
    refl_d    = wr_refl_i     ? wr_data_i[0]            : refl_q;
    vdel_d    = wr_vdel_i     ? wr_data_i[0]            : vdel_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gfx_new_q <= '0;
      gfx_old_q <= '0;
      size_q    <= '0;
      refl_q    <= 1'b0;
      vdel_q    <= 1'b0;
    end else begin
      gfx_new_q <= gfx_new_d;
      gfx_old_q <= gfx_old_d;
      size_q    <= size_d;
      refl_q    <= refl_d;
      vdel_q    <= vdel_d;
    end
  end

  assign size_cfg = size_decode(size_q);
  assign tick     = !hblank_i && !hold;

  movobj_motion #(
    .MOT_W    (MOT_W),
    .LATE_CLKS(LATE_CLKS),
    .EXTRA_GAP(EXTRA_GAP)
  ) motion_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .hblank_i  (hblank_i),
    .wr_mot_i  (wr_motion_i),
    .mot_data_i(wr_data_i[GFX_W-1 -: MOT_W]),
    .mclr_i    (mclr_i),
    .hmove_i   (hmove_i),
    .extra_o   (extra),
    .hold_o    (hold)
  );

  movobj_poscnt #(
    .LINE_PIX (LINE_PIX),
    .COPY_NEAR(COPY_NEAR),
    .COPY_MID (COPY_MID),
    .COPY_FAR (COPY_FAR)
  ) poscnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .extra_i    (extra),
    .pos_rst_i  (pos_rst_i),
    .copy_mask_i(size_cfg.copy_mask),
    .cnt_clk_o  (cnt_clk),
    .start_o    (start)
  );

  movobj_scan #(
    .GFX_W (GFX_W),
    .WLOG_W(WLOG_W)
  ) scan_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cnt_clk_i(cnt_clk),
    .start_i  (start),
    .vis_i    (tick),
    .gfx_i    (vdel_q ? gfx_old_q : gfx_new_q),
    .refl_i   (refl_q),
    .wlog_i   (size_cfg.wlog),
    .pix_o    (pix_o)
  );

  // R8
  own_write_keeps_delayed_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_gfx_i && !wr_peer_gfx_i) |=> $stable(gfx_old_q));

  // R6
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(hblank_i) |-> !pix_o);

endmodule

// File: tb/movobj_engine_tb_top.sv
module movobj_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_PIX   = 160;
  localparam int BLANK      = 68;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hblank, wr_gfx, wr_peer, wr_size, wr_refl, wr_vdel, wr_mot, mclr, hmove, pos_rst;
  logic [7:0] wdata;
  logic       pix;

  int total = 0;
  int bad   = 0;
  int bcnt  = 0;

  typedef struct {
    logic [LINE_PIX-1:0] exp;
    bit                  chk;
    string               tag;
  } item_t;

  item_t sbq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  movobj_engine dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hblank_i     (hblank),
    .wr_data_i    (wdata),
    .wr_gfx_i     (wr_gfx),
    .wr_peer_gfx_i(wr_peer),
    .wr_size_i    (wr_size),
    .wr_refl_i    (wr_refl),
    .wr_vdel_i    (wr_vdel),
    .wr_motion_i  (wr_mot),
    .mclr_i       (mclr),
    .hmove_i      (hmove),
    .pos_rst_i    (pos_rst),
    .pix_o        (pix)
  );

  // Monitor: each visible edge yields one column, sampled at the following falling edge
  logic                hb_s;
  logic [LINE_PIX-1:0] cap;
  int                  col = 0;

  always @(posedge clk) hb_s <= hblank;

  always @(negedge clk) begin
    if (hb_s == 1'b0) begin
      cap[col] = pix;
      col++;
      if (col == LINE_PIX) begin
        col = 0;
        if (sbq.size() == 0) begin
          total++; bad++;
          $display("FAIL R1 scoreboard: actual=unexpected line expected=no line");
        end else begin
          item_t it;
          it = sbq.pop_front();
          if (it.chk) begin
            total++;
            if (cap !== it.exp) begin
              bad++;
              $display("FAIL %s: actual=%h expected=%h", it.tag, cap, it.exp);
            end
          end
        end
      end
    end
  end

  function automatic logic [LINE_PIX-1:0] obj_row(input int p, input int sz,
                                                  input logic [7:0] g, input bit rf);
    logic [LINE_PIX-1:0] r;
    int offs [3];
    int w;
    r    = '0;
    w    = 1;
    offs = '{0, -1, -1};
    case (sz)
      1: offs = '{0, 16, -1};
      2: offs = '{0, 32, -1};
      3: offs = '{0, 16, 32};
      4: offs = '{0, 64, -1};
      5: w = 2;
      6: offs = '{0, 32, 64};
      7: w = 4;
      default: ;
    endcase
    for (int j = 0; j < 3; j++) begin
      if (offs[j] >= 0) begin
        for (int k = 0; k < 8 * w; k++) begin
          int c;
          c = p + offs[j] + k;
          if (c < LINE_PIX) r[c] = rf ? g[k / w] : g[7 - k / w];
        end
      end
    end
    return r;
  endfunction

  task automatic idle_inputs();
    wr_gfx = 0; wr_peer = 0; wr_size = 0; wr_refl = 0; wr_vdel = 0;
    wr_mot = 0; mclr = 0; hmove = 0; pos_rst = 0;
  endtask

  // First blank cycle of a line, optionally carrying the move strobe
  task automatic start_blank(input bit hm);
    @(negedge clk);
    idle_inputs();
    hblank = 1'b1;
    hmove  = hm;
    bcnt   = 1;
  endtask

  // One blank cycle with a single write strobe; sel: 0 gfx 1 peer 2 size 3 refl 4 vdel 5 motion 6 clear 7 posrst
  task automatic blank_wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    idle_inputs();
    wdata = d;
    case (sel)
      0: wr_gfx  = 1'b1;
      1: wr_peer = 1'b1;
      2: wr_size = 1'b1;
      3: wr_refl = 1'b1;
      4: wr_vdel = 1'b1;
      5: wr_mot  = 1'b1;
      6: mclr    = 1'b1;
      default: pos_rst = 1'b1;
    endcase
    bcnt++;
  endtask

  // Driver: push the expected row, finish the blank, run the visible part
  task automatic finish_line(input logic [LINE_PIX-1:0] exp, input bit chk,
                             input string tag, input int rst_col);
    item_t it;
    it.exp = exp; it.chk = chk; it.tag = tag;
    sbq.push_back(it);
    while (bcnt < BLANK) begin
      @(negedge clk);
      idle_inputs();
      bcnt++;
    end
    for (int v = 0; v < LINE_PIX; v++) begin
      @(negedge clk);
      idle_inputs();
      hblank  = 1'b0;
      pos_rst = (v == rst_col);
    end
  endtask

  task automatic plain_line(input logic [LINE_PIX-1:0] exp, input string tag);
    start_blank(1'b0);
    finish_line(exp, 1'b1, tag, -1);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=still running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] g;
    int p;
    rst_n  = 1'b0;
    hblank = 1'b1;
    wdata  = '0;
    idle_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    total++;
    if (pix !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: actual=%b expected=0", pix);
    end

    // R10: graphics cleared by reset, nothing drawn even after a placement
    start_blank(1'b0);
    blank_wr(7, 8'h00);
    finish_line('0, 1'b1, "R10 empty graphics", -1);

    g = 8'hC1;
    // R2: placement during blank gives column 0
    start_blank(1'b0);
    blank_wr(0, g);
    finish_line(obj_row(0, 0, g, 0), 1'b1, "R2 blank reset", -1);

    // R2: reset on visible column 40 starts a copy at 41 on this line
    start_blank(1'b0);
    finish_line(obj_row(0, 0, g, 0) | obj_row(41, 0, g, 0), 1'b1, "R2 visible reset", 40);
    p = 41;
    plain_line(obj_row(p, 0, g, 0), "R1 steady column");
    plain_line(obj_row(p, 0, g, 0), "R1 steady again");

    // R3: copy encodings
    for (int s = 1; s <= 6; s++) begin
      if (s != 5) begin
        start_blank(1'b0);
        blank_wr(2, 8'(s));
        finish_line(obj_row(p, s, g, 0), 1'b1, "R3 copies", -1);
      end
    end

    // R4: stretched widths
    start_blank(1'b0);
    blank_wr(2, 8'd5);
    finish_line(obj_row(p, 5, g, 0), 1'b1, "R4 width 16", -1);
    start_blank(1'b0);
    blank_wr(2, 8'd7);
    finish_line(obj_row(p, 7, g, 0), 1'b1, "R4 width 32", -1);

    // R5: reflection
    start_blank(1'b0);
    blank_wr(2, 8'd0);
    blank_wr(3, 8'h01);
    finish_line(obj_row(p, 0, g, 1), 1'b1, "R5 reflected", -1);
    start_blank(1'b0);
    blank_wr(3, 8'h00);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R5 normal", -1);

    // R6 and R7: motion
    start_blank(1'b0);
    blank_wr(5, 8'h30);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R6 load without strobe", -1);
    start_blank(1'b1);
    blank_wr(5, 8'hB0);
    p = p - 3;
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R6 plus three", -1);
    plain_line(obj_row(p, 0, g, 0), "R6 applied once");
    start_blank(1'b1);
    blank_wr(6, 8'h00);
    p = p + 5;
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R6 minus five", -1);
    start_blank(1'b1);
    blank_wr(5, 8'h70);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R7 cleared no shift", -1);
    start_blank(1'b1);
    blank_wr(5, 8'h80);
    p = p - 7;
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R6 plus seven", -1);
    start_blank(1'b1);
    p = p + 8;
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R6 minus eight", -1);
    plain_line(obj_row(p, 0, g, 0), "R6 holds after move");

    // R8: vertical delay
    start_blank(1'b0);
    blank_wr(4, 8'h01);
    finish_line('0, 1'b1, "R8 delayed empty", -1);
    start_blank(1'b0);
    blank_wr(1, 8'h00);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R8 peer copy", -1);
    start_blank(1'b0);
    blank_wr(0, 8'h18);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R8 delayed kept", -1);
    start_blank(1'b0);
    blank_wr(4, 8'h00);
    finish_line(obj_row(p, 0, 8'h18, 0), 1'b1, "R8 direct", -1);

    // R9: start decode during an active scan is ignored
    g = 8'h81;
    start_blank(1'b0);
    blank_wr(0, g);
    finish_line(obj_row(p, 0, g, 0), 1'b1, "R9 scan not restarted", p + 3);
    p = p + 4;
    plain_line(obj_row(p, 0, g, 0), "R9 new column");

    @(negedge clk);
    idle_inputs();
    hblank = 1'b1;
    repeat (3) @(negedge clk);

    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R1 scoreboard drain: actual=%0d expected=0", sbq.size());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule